// File: doc/BRIEF.md
# Threshold Canonical Huffman Encoder

This block turns a 9-bit rank index into a canonical Huffman codeword without walking any tree. The index is compared at the same time against every group start value. The largest start that is not above the index picks a group, and the group sets the codeword length. Inside a group the codewords run consecutively, so the codeword is the group's first code plus the distance of the index from the group start. The result is right-aligned in a 12-bit field and comes with a 4-bit length.

The group starts and the per-group lengths are parameters. The first code of each group is worked out at elaboration from the group sizes, in the usual canonical order. Index 0 forms a group of its own, below the first listed start, and gets the shortest code.

The default table has these groups:

| Indices | Length | First code |
|---|---|---|
| 0 | 5 | 0 |
| 1..8 | 5 | 1 |
| 9..17 | 5 | 9 |
| 18..30 | 8 | 144 |
| 31..100 | 8 | 157 |
| 101..153 | 11 | 1816 |
| 154..170 | 12 | 3738 |
| 171..185 | 12 | 3755 |
| 186..511 | 12 | 3770 |

This default table fills the code space exactly.

Both sides use valid/ready handshakes, and a word moves when valid and ready are both high at a clock edge. The input is ready whenever the output register is empty or is being emptied in the same cycle. While the output holds a word that has not been taken, the input is not ready and the output word stays unchanged. The encoder accepts one index per cycle and has one cycle of latency.

Top module: `chuff_enc`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The codeword length is set by the group holding the index. Indices 0 to 17 get length 5, indices 18 to 100 get length 8, indices 101 to 153 get length 11, and indices 154 to 511 get length 12.
- R3: The codeword is the group's first code plus (index minus group start). The group starts are 0, 1, 9, 18, 31, 101, 154, 171 and 186, and the first codes are 0, 1, 9, 144, 157, 1816, 3738, 3755 and 3770 in that order. The code is right-aligned in out_code, and every bit at or above out_len is 0.
- R4: Index 38 is coded as value 164 with length 8.
- R5: Index 0 is coded as value 0 with length 5, and no index has a shorter code.
- R6: An index accepted at a clock edge appears on the output, with out_valid high, right after that edge.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_code and out_len stay unchanged.
- R8: With out_ready held at 1, one index is accepted per cycle, and the codewords come out in the same order as the indices went in.
- R9: Over all 512 indices the code is prefix-free, and the sum of 2^-length over all codewords is exactly 1.
- R10: When the output word is taken and no new index is accepted in the same cycle, out_valid is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An index is offered |
| in_ready | output | 1 | The encoder can take an index this cycle |
| in_idx | input | 9 | Rank index to encode |
| out_valid | output | 1 | out_code and out_len hold a codeword |
| out_ready | input | 1 | The consumer takes the codeword this cycle |
| out_code | output | 12 | Codeword, right-aligned, upper bits zero |
| out_len | output | 4 | Codeword length in bits |

## Verification
The properties assume a group start table that rises from zero and lengths that never shrink from one group to the next. They also assume that in_idx carries a defined value whenever in_valid is high. The fixed-value properties (index 0, index 38 and the top group) hold only for the default table, which is the table the stimulus uses. The stimulus changes inputs only on the falling clock edge, and it keeps offering the same index while the output is stalled. Because of this, acceptance always happens cleanly at a rising edge, and a stalled word is never replaced.

// File: rtl/chuff_pkg.sv
package chuff_pkg;

  localparam int CH_IDX_W = 9;
  localparam int CH_LEN_W = 4;
  localparam int CH_NGRP  = 9;

  // Group start indices, ascending; element 0 must be zero.
  localparam logic [CH_NGRP-1:0][CH_IDX_W-1:0] CH_START_DEF = {
    9'd186, 9'd171, 9'd154, 9'd101, 9'd31, 9'd18, 9'd9, 9'd1, 9'd0
  };

  // Codeword length per group, non-decreasing with the group number.
  localparam logic [CH_NGRP-1:0][CH_LEN_W-1:0] CH_LEN_DEF = {
    4'd12, 4'd12, 4'd12, 4'd11, 4'd8, 4'd8, 4'd5, 4'd5, 4'd5
  };

endpackage

// File: rtl/chuff_grp_sel.sv
module chuff_grp_sel #(
  parameter int IDX_W = 9,
  parameter int NGRP  = 9,
  parameter logic [NGRP-1:0][IDX_W-1:0] GRP_START = '0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [NGRP-1:0]  grp_oh
);

  logic [NGRP-1:0] at_or_above;

  // One comparator per group start, all evaluated at once.
  for (genvar g = 0; g < NGRP; g++) begin : g_cmp
    assign at_or_above[g] = (idx >= GRP_START[g]);
  end

  // Starts ascend, so the compare results form a thermometer code.
  // The selected group is the top set bit of that code.
  for (genvar g = 0; g < NGRP; g++) begin : g_edge
    if (g == NGRP - 1) begin : g_top
      assign grp_oh[g] = at_or_above[g];
    end else begin : g_mid
      assign grp_oh[g] = at_or_above[g] & ~at_or_above[g+1];
    end
  end

endmodule

// File: rtl/chuff_code_form.sv
module chuff_code_form #(
  parameter int IDX_W  = 9,
  parameter int LEN_W  = 4,
  parameter int NGRP   = 9,
  parameter int CODE_W = 12,
  parameter logic [NGRP-1:0][IDX_W-1:0] GRP_START = '0,
  parameter logic [NGRP-1:0][LEN_W-1:0] GRP_LEN   = '0
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [NGRP-1:0]   grp_oh,
  output logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len
);

  // Canonical first code of each group, computed from the group sizes:
  // next group's first = (previous first + previous size) shifted left
  // by the growth in length.
  function automatic logic [NGRP-1:0][CODE_W-1:0] calc_first();
    logic [NGRP-1:0][CODE_W-1:0] f;
    longint nxt;
    longint top;
    f   = '0;
    nxt = 0;
    for (int g = 0; g < NGRP; g++) begin
      if (g > 0) begin
        nxt = nxt <<< (int'(GRP_LEN[g]) - int'(GRP_LEN[g-1]));
      end
      f[g] = nxt[CODE_W-1:0];
      if (g < NGRP - 1) begin
        top = longint'(GRP_START[g+1]);
      end else begin
        top = longint'(1) <<< IDX_W;
      end
      nxt = nxt + top - longint'(GRP_START[g]);
    end
    return f;
  endfunction

  localparam logic [NGRP-1:0][CODE_W-1:0] GRP_FIRST = calc_first();

  logic [IDX_W-1:0]  start_sel;
  logic [CODE_W-1:0] first_sel;
  logic [LEN_W-1:0]  len_sel;
  logic [IDX_W-1:0]  offset;

  // AND-OR multiplexer over the one-hot group select.
  always_comb begin
    start_sel = '0;
    first_sel = '0;
    len_sel   = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_oh[g]) begin
        start_sel |= GRP_START[g];
        first_sel |= GRP_FIRST[g];
        len_sel   |= GRP_LEN[g];
      end
    end
  end

  assign offset = idx - start_sel;
  assign code   = first_sel + CODE_W'(offset);
  assign len    = len_sel;

endmodule

// File: rtl/chuff_out_stage.sv
module chuff_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);

  // The stage may load when it is empty or is being drained this cycle.
  assign up_ready = ~dn_valid | dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) begin
        dn_data <= up_data;
      end
    end
  end

endmodule

// File: rtl/chuff_enc.sv
module chuff_enc #(
  parameter int IDX_W = chuff_pkg::CH_IDX_W,
  parameter int LEN_W = chuff_pkg::CH_LEN_W,
  parameter int NGRP  = chuff_pkg::CH_NGRP,
  parameter logic [NGRP-1:0][IDX_W-1:0] GRP_START = chuff_pkg::CH_START_DEF,
  parameter logic [NGRP-1:0][LEN_W-1:0] GRP_LEN   = chuff_pkg::CH_LEN_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IDX_W-1:0]       in_idx,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [max_len()-1:0]   out_code,
  output logic [LEN_W-1:0]       out_len
);

  // The code field is as wide as the longest codeword in the table.
  function automatic int max_len();
    int m;
    m = 1;
    for (int g = 0; g < NGRP; g++) begin
      if (int'(GRP_LEN[g]) > m) m = int'(GRP_LEN[g]);
    end
    return m;
  endfunction

  localparam int CODE_W = max_len();
  localparam int DW     = CODE_W + LEN_W;

  logic [NGRP-1:0]   grp_oh;
  logic [CODE_W-1:0] code_c;
  logic [LEN_W-1:0]  len_c;
  logic [DW-1:0]     word_c;
  logic [DW-1:0]     word_q;

  chuff_grp_sel #(
    .IDX_W     (IDX_W),
    .NGRP      (NGRP),
    .GRP_START (GRP_START)
  ) u_sel (
    .idx    (in_idx),
    .grp_oh (grp_oh)
  );

  chuff_code_form #(
    .IDX_W     (IDX_W),
    .LEN_W     (LEN_W),
    .NGRP      (NGRP),
    .CODE_W    (CODE_W),
    .GRP_START (GRP_START),
    .GRP_LEN   (GRP_LEN)
  ) u_form (
    .idx    (in_idx),
    .grp_oh (grp_oh),
    .code   (code_c),
    .len    (len_c)
  );

  assign word_c = {len_c, code_c};

  chuff_out_stage #(
    .DW (DW)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (word_c),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (word_q)
  );

  assign out_code = word_q[CODE_W-1:0];
  assign out_len  = word_q[DW-1:CODE_W];

endmodule

// File: rtl/chuff_enc_chk.sv
module chuff_enc_chk #(
  parameter int IDX_W  = 9,
  parameter int LEN_W  = 4,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [IDX_W-1:0]  in_idx,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic [LEN_W-1:0]  out_len
);

  AST_TOP_GROUP_LEN: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready && (in_idx >= 186) |=> out_len == 12); // R2
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_code >> out_len) == '0); // R3
  AST_IDX38_CODE: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready && (in_idx == 38) |=> out_code == 164 && out_len == 8); // R4
  AST_IDX0_CODE: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready && (in_idx == 0) |=> out_code == 0 && out_len == 5); // R5
  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> out_valid); // R6
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |-> !in_ready); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_len)); // R7
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_ready && !in_valid |=> !out_valid); // R10

endmodule

bind chuff_enc chuff_enc_chk #(
  .IDX_W  (IDX_W),
  .LEN_W  (LEN_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_idx    (in_idx),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code  (out_code),
  .out_len   (out_len)
);

// File: tb/test_chuff_enc.sv
`timescale 1ns/1ps
module test_chuff_enc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_idx = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_code;
  logic [3:0]  out_len;

  int n_cmp = 0;
  int n_bad = 0;
  int seen_code [512];
  int seen_len  [512];

  always #2.5 clk = ~clk;

  chuff_enc i_chuff_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_idx    (in_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_len   (out_len)
  );

  // Expected length per index, from the group table in the requirements.
  function automatic int ref_len(int i);
    if (i < 18)  return 5;
    if (i < 101) return 8;
    if (i < 154) return 11;
    return 12;
  endfunction

  // Expected code: group first code plus offset from the group start.
  function automatic int ref_code(int i);
    if (i == 0)  return 0;
    if (i < 9)   return 1 + (i - 1);
    if (i < 18)  return 9 + (i - 9);
    if (i < 31)  return 144 + (i - 18);
    if (i < 101) return 157 + (i - 31);
    if (i < 154) return 1816 + (i - 101);
    if (i < 171) return 3738 + (i - 154);
    if (i < 186) return 3755 + (i - 171);
    return 3770 + (i - 186);
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_word(string tag, int idx);
    check_eq({tag, " valid"}, int'(out_valid), 1);
    check_eq({tag, " code"}, int'(out_code), ref_code(idx));
    check_eq({tag, " len"}, int'(out_len), ref_len(idx));
  endtask

  // R1: state right after reset release
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 out_valid", int'(out_valid), 0);
    check_eq("R1 in_ready", int'(in_ready), 1);
  endtask

  // Single index through an idle encoder; R6 latency plus value checks
  task automatic t_single(string tag, int idx);
    @(negedge clk);
    in_idx   = 9'(idx);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_word({"R6 ", tag}, idx);
    @(negedge clk);
    check_eq({"R10 ", tag}, int'(out_valid), 0);
  endtask

  // R2, R3: both edges of every group
  task automatic t_boundaries();
    int edges [18] = '{0, 1, 8, 9, 17, 18, 30, 31, 100, 101, 153, 154, 170, 171, 185, 186, 300, 511};
    foreach (edges[k]) t_single("R2 R3 boundary", edges[k]);
  endtask

  // R8 back-to-back stream of all indices, then R9 prefix and Kraft checks
  task automatic t_sweep();
    longint kraft;
    int     clash;
    out_ready = 1'b1;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check_word("R8 stream", i - 1);
        check_eq("R8 in_ready", int'(in_ready), 1);
        seen_code[i-1] = int'(out_code);
        seen_len[i-1]  = int'(out_len);
      end
      in_idx   = 9'(i);
      in_valid = 1'b1;
    end
    @(negedge clk);
    check_word("R8 stream", 511);
    seen_code[511] = int'(out_code);
    seen_len[511]  = int'(out_len);
    in_valid = 1'b0;
    @(negedge clk);
    check_eq("R10 after stream", int'(out_valid), 0);

    kraft = 0;
    clash = 0;
    for (int a = 0; a < 512; a++) begin
      kraft += longint'(1) <<< (12 - seen_len[a]);
      for (int b = 0; b < 512; b++) begin
        if (a != b && seen_len[a] <= seen_len[b]) begin
          if ((seen_code[b] >> (seen_len[b] - seen_len[a])) == seen_code[a]) clash++;
        end
      end
    end
    check_eq("R9 prefix clashes", clash, 0);
    check_eq("R9 Kraft sum x4096", int'(kraft), 4096);
    for (int a = 0; a < 512; a++) begin
      if (seen_len[a] < seen_len[0]) check_eq("R5 shortest", seen_len[a], seen_len[0]);
    end
  endtask

  // R7 stall: output held, input refused, then released in order
  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_idx    = 9'd77;
    in_valid  = 1'b1;
    @(negedge clk);
    check_word("R7 first word", 77);
    in_idx = 9'd160;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_eq("R7 in_ready low", int'(in_ready), 0);
      check_word("R7 held word", 77);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_word("R7 released next", 160);
    @(negedge clk);
    check_eq("R10 after stall", int'(out_valid), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single("R5 index zero", 0);
    t_single("R4 index 38", 38);
    t_boundaries();
    t_stall();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule